// File: doc/BRIEF.md
# Dual Shared-Gain Audio Limiter

This block computes gain reduction for a small group of audio processing channels using two independent limiter engines. Each channel is routed to limiter one, to limiter two, or to neither. A limiter looks at the log-domain levels of the channels routed to it. When that level rises above an attack threshold, it removes gain in programmable steps. When the level falls below a release threshold, it gives the gain back in programmable steps. It can only give back gain it has already removed, so the release threshold behaves like a floor on the remaining dynamic range.

A single mode input selects how the thresholds are read. In clip-guard mode, thresholds are absolute, in dB relative to full scale. In compressor mode, thresholds are taken relative to the current volume setting, which is supplied on `vol_db`. Thresholds are chosen with 4-bit codes from mode-specific tables. An upstream envelope stage delivers one frame per sample period: a signed level in whole dB for every channel, where 0 means full scale.

Frames enter on a valid/ready stream and leave on a valid/ready stream. Each output frame carries the gain reduction, in whole dB, that applies to each channel. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. An output held under back-pressure keeps its contents unchanged until `out_ready` accepts it. Configuration pins are plain levels that are sampled on every accepted frame.

Top module: `dual_limiter`

## Requirements
- R1: During reset and just after it, both limiter reductions are 0, `out_valid` is 0 and every channel of `out_atten` is 0.
- R2: `in_ready` equals `!out_valid || out_ready`. A frame is accepted when `in_valid && in_ready`, and its result is visible with `out_valid` high on the next cycle. While `out_valid && !out_ready`, `out_valid` stays high and `out_atten` does not change.
- R3: Each channel has a 2-bit routing field in `cfg_map` (channel c at bits 2c+1:2c): 01 selects limiter one, 10 selects limiter two, and 00 or 11 selects no limiter. A channel with no limiter reports 0 in `out_atten` and takes no part in any detection.
- R4: A limiter's detected level is the maximum of the levels of its routed channels. A limiter with no routed channel never attacks and always releases.
- R5: If the detected level is strictly above the attack threshold, the reduction grows by the limiter's attack step (0..15 dB). The reduction saturates at MAXRED (96 dB by default).
- R6: Otherwise, if the level is strictly below the release threshold, the reduction shrinks by the release step and never goes below 0. A level between the two thresholds (inclusive) leaves the reduction unchanged. When both conditions hold, attack wins.
- R7: In clip-guard mode (`cfg_mode`=0), attack code n means n-12 dBFS.
- R8: In clip-guard mode, release code 0 means minus infinity, which is treated as always release. Codes 1, 2, 3 and 4 mean -29, -20, -16 and -14 dBFS. A code n of 5 or more means n-17 dBFS.
- R9: In compressor mode (`cfg_mode`=1), attack codes 0 to 15 mean -31, -29, -27, -25, -23, -21, -19, -17, -16, -15, -14, -13, -12, -10, -7 and -4 dB. `vol_db` is added to each of these values.
- R10: In compressor mode, release code n means 2n-38 dB plus `vol_db`.
- R11: The reductions change only on accepted frames. `out_lim_atten` shows limiter one in bits GW-1:0 and limiter two above it. A routed channel's `out_atten` equals the new reduction of its limiter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | 0 clip-guard, 1 compressor |
| cfg_map | input | 2*NCH | Per-channel limiter routing |
| cfg_atk_code | input | 8 | Attack threshold codes, limiter one in bits 3:0 |
| cfg_rel_code | input | 8 | Release threshold codes, limiter one in bits 3:0 |
| cfg_atk_step | input | 8 | Attack steps in dB, limiter one in bits 3:0 |
| cfg_rel_step | input | 8 | Release steps in dB, limiter one in bits 3:0 |
| vol_db | input | LW | Signed volume setting in dB |
| in_valid | input | 1 | Input frame valid |
| in_ready | output | 1 | Input frame accepted when high with valid |
| in_level | input | NCH*LW | Signed per-channel level in dBFS |
| out_valid | output | 1 | Output frame valid |
| out_ready | input | 1 | Consumer accepts output frame |
| out_atten | output | NCH*GW | Per-channel gain reduction in dB |
| out_lim_atten | output | 2*GW | Current reduction of each limiter |

## Verification
The bench targets several corner cases, and each one has a recognisable failure signature. At the threshold boundaries it drives a level equal to the threshold: an off-by-one comparison would attack or release where it should hold. It pushes the reduction into the 96 dB ceiling and then releases it down past zero: missing saturation or a missing floor shows up as wrap-around in `out_lim_atten`. It uses the minus-infinity release code and a limiter with no routed channels: both must keep decaying, and a broken design would freeze the gain. It runs random stalls on `out_ready` together with reserved routing code 11: a faulty design would let a held frame change or would leak attenuation onto an unrouted channel.

// File: rtl/dlim_pkg.sv
package dlim_pkg;
  localparam int NLIM = 2;
  localparam int CODEW = 4;
  localparam int STEPW = 4;
  localparam int MAPW = 2;

  typedef enum logic [1:0] {
    MAP_NONE = 2'b00,
    MAP_L1   = 2'b01,
    MAP_L2   = 2'b10,
    MAP_OFF  = 2'b11
  } map_e;

  typedef enum logic {
    MODE_CLIP = 1'b0,
    MODE_COMP = 1'b1
  } mode_e;
endpackage

// File: rtl/dlim_thr_dec.sv
module dlim_thr_dec #(
  parameter int LW = 8,
  parameter int TW = LW + 2
) (
  input  logic                 mode,
  input  logic [3:0]           atk_code,
  input  logic [3:0]           rel_code,
  input  logic signed [LW-1:0] vol,
  output logic signed [TW-1:0] atk_thr,
  output logic signed [TW-1:0] rel_thr,
  output logic                 rel_always
);
  import dlim_pkg::*;

  logic signed [7:0]    atk_base;
  logic signed [7:0]    rel_base;
  logic signed [TW-1:0] vol_ext;
  logic signed [TW-1:0] offset;

  always_comb begin
    if (mode == MODE_CLIP) begin
      atk_base = $signed({4'b0000, atk_code}) - 8'sd12;
      unique case (rel_code)
        4'd0:    rel_base = -8'sd128;
        4'd1:    rel_base = -8'sd29;
        4'd2:    rel_base = -8'sd20;
        4'd3:    rel_base = -8'sd16;
        4'd4:    rel_base = -8'sd14;
        default: rel_base = $signed({4'b0000, rel_code}) - 8'sd17;
      endcase
    end else begin
      unique case (atk_code)
        4'd0:  atk_base = -8'sd31;
        4'd1:  atk_base = -8'sd29;
        4'd2:  atk_base = -8'sd27;
        4'd3:  atk_base = -8'sd25;
        4'd4:  atk_base = -8'sd23;
        4'd5:  atk_base = -8'sd21;
        4'd6:  atk_base = -8'sd19;
        4'd7:  atk_base = -8'sd17;
        4'd8:  atk_base = -8'sd16;
        4'd9:  atk_base = -8'sd15;
        4'd10: atk_base = -8'sd14;
        4'd11: atk_base = -8'sd13;
        4'd12: atk_base = -8'sd12;
        4'd13: atk_base = -8'sd10;
        4'd14: atk_base = -8'sd7;
        default: atk_base = -8'sd4;
      endcase
      rel_base = $signed({3'b000, rel_code, 1'b0}) - 8'sd38;
    end
  end

  assign vol_ext    = {{(TW-LW){vol[LW-1]}}, vol};
  assign offset     = (mode == MODE_COMP) ? vol_ext : '0;
  assign atk_thr    = {{(TW-8){atk_base[7]}}, atk_base} + offset;
  assign rel_thr    = {{(TW-8){rel_base[7]}}, rel_base} + offset;
  assign rel_always = (mode == MODE_CLIP) && (rel_code == 4'd0);
endmodule

// File: rtl/dlim_peak.sv
module dlim_peak #(
  parameter int NCH = 3,
  parameter int LW  = 8,
  parameter int IDX = 0
) (
  input  logic [NCH*LW-1:0]    levels,
  input  logic [2*NCH-1:0]     map,
  output logic signed [LW-1:0] peak,
  output logic                 any
);
  import dlim_pkg::*;

  localparam logic [1:0] SEL = (IDX == 0) ? MAP_L1 : MAP_L2;

  always_comb begin
    peak = {1'b1, {(LW-1){1'b0}}};
    any  = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (map[2*c +: 2] == SEL) begin
        if (!any || ($signed(levels[c*LW +: LW]) > peak)) begin
          peak = $signed(levels[c*LW +: LW]);
        end
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dlim_gain.sv
module dlim_gain #(
  parameter int TW     = 10,
  parameter int GW     = 8,
  parameter int SW     = 4,
  parameter int MAXRED = 96
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic                 any,
  input  logic signed [TW-1:0] peak,
  input  logic signed [TW-1:0] atk_thr,
  input  logic signed [TW-1:0] rel_thr,
  input  logic                 rel_always,
  input  logic [SW-1:0]        atk_step,
  input  logic [SW-1:0]        rel_step,
  output logic [GW-1:0]        red_q,
  output logic [GW-1:0]        red_d
);
  localparam logic [GW:0] CEIL = (GW+1)'(MAXRED);

  logic        over;
  logic        under;
  logic [GW:0] sum;
  logic [GW-1:0] rel_ext;

  assign over    = any && (peak > atk_thr);
  assign under   = !any || rel_always || (peak < rel_thr);
  assign sum     = {1'b0, red_q} + {{(GW+1-SW){1'b0}}, atk_step};
  assign rel_ext = {{(GW-SW){1'b0}}, rel_step};

  always_comb begin
    if (over) begin
      red_d = (sum > CEIL) ? CEIL[GW-1:0] : sum[GW-1:0];
    end else if (under) begin
      red_d = (red_q > rel_ext) ? (red_q - rel_ext) : '0;
    end else begin
      red_d = red_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      red_q <= '0;
    end else if (fire) begin
      red_q <= red_d;
    end
  end
endmodule

// File: rtl/dual_limiter.sv
module dual_limiter #(
  parameter int NCH    = 3,
  parameter int LW     = 8,
  parameter int GW     = 8,
  parameter int MAXRED = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mode,
  input  logic [2*NCH-1:0]  cfg_map,
  input  logic [7:0]        cfg_atk_code,
  input  logic [7:0]        cfg_rel_code,
  input  logic [7:0]        cfg_atk_step,
  input  logic [7:0]        cfg_rel_step,
  input  logic [LW-1:0]     vol_db,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [NCH*LW-1:0] in_level,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NCH*GW-1:0] out_atten,
  output logic [2*GW-1:0]   out_lim_atten
);
  import dlim_pkg::*;

  localparam int TW = LW + 2;

  logic            fire;
  logic [GW-1:0]   lim_red_q [NLIM];
  logic [GW-1:0]   lim_red_d [NLIM];
  logic [NCH*GW-1:0] chan_d;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  for (genvar l = 0; l < NLIM; l++) begin : g_lim
    logic signed [LW-1:0] peak;
    logic                 any;
    logic signed [TW-1:0] peak_ext;
    logic signed [TW-1:0] atk_thr;
    logic signed [TW-1:0] rel_thr;
    logic                 rel_always;

    dlim_peak #(.NCH(NCH), .LW(LW), .IDX(l)) u_peak (
      .levels (in_level),
      .map    (cfg_map),
      .peak   (peak),
      .any    (any)
    );

    assign peak_ext = {{(TW-LW){peak[LW-1]}}, peak};

    dlim_thr_dec #(.LW(LW), .TW(TW)) u_dec (
      .mode       (cfg_mode),
      .atk_code   (cfg_atk_code[l*CODEW +: CODEW]),
      .rel_code   (cfg_rel_code[l*CODEW +: CODEW]),
      .vol        ($signed(vol_db)),
      .atk_thr    (atk_thr),
      .rel_thr    (rel_thr),
      .rel_always (rel_always)
    );

    dlim_gain #(.TW(TW), .GW(GW), .SW(STEPW), .MAXRED(MAXRED)) u_gain (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (fire),
      .any        (any),
      .peak       (peak_ext),
      .atk_thr    (atk_thr),
      .rel_thr    (rel_thr),
      .rel_always (rel_always),
      .atk_step   (cfg_atk_step[l*STEPW +: STEPW]),
      .rel_step   (cfg_rel_step[l*STEPW +: STEPW]),
      .red_q      (lim_red_q[l]),
      .red_d      (lim_red_d[l])
    );

    assign out_lim_atten[l*GW +: GW] = lim_red_q[l];
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      unique case (cfg_map[2*c +: 2])
        MAP_L1:  chan_d[c*GW +: GW] = lim_red_d[0];
        MAP_L2:  chan_d[c*GW +: GW] = lim_red_d[1];
        default: chan_d[c*GW +: GW] = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_atten <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_atten <= chan_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dlim_checker.sv
module dlim_checker #(
  parameter int NCH    = 3,
  parameter int GW     = 8,
  parameter int MAXRED = 96
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [NCH*GW-1:0] out_atten,
  input logic [2*GW-1:0]   out_lim_atten
);
  // R2: an empty output register never blocks the input
  a_r2_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R2: a stalled frame stays valid and unchanged
  a_r2_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_atten)));

  // R11: no accepted frame, no change of limiter state
  a_r11_state_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(out_lim_atten));

  for (genvar l = 0; l < 2; l++) begin : g_chk
    // R5: reduction never passes the ceiling
    a_r5_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      out_lim_atten[l*GW +: GW] <= GW'(MAXRED));

    // R5: one accepted frame moves a reduction by at most one 4-bit step
    a_r5_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=>
        (((out_lim_atten[l*GW +: GW] > $past(out_lim_atten[l*GW +: GW]))
          ? (out_lim_atten[l*GW +: GW] - $past(out_lim_atten[l*GW +: GW]))
          : ($past(out_lim_atten[l*GW +: GW]) - out_lim_atten[l*GW +: GW]))
         <= GW'(15)));
  end
endmodule

bind dual_limiter dlim_checker #(.NCH(NCH), .GW(GW), .MAXRED(MAXRED)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_atten     (out_atten),
  .out_lim_atten (out_lim_atten)
);

// File: tb/dual_limiter_test.sv
`timescale 1ns/1ps
module dual_limiter_test;
  localparam int NCH = 3;
  localparam int LW = 8;
  localparam int GW = 8;
  localparam int MAXRED = 96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_mode = 1'b0;
  logic [2*NCH-1:0] cfg_map = '0;
  logic [7:0] cfg_atk_code = '0, cfg_rel_code = '0, cfg_atk_step = '0, cfg_rel_step = '0;
  logic [LW-1:0] vol_db = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [NCH*LW-1:0] in_level = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [NCH*GW-1:0] out_atten;
  logic [2*GW-1:0] out_lim_atten;

  always #2 clk = ~clk;

  dual_limiter #(.NCH(NCH), .LW(LW), .GW(GW), .MAXRED(MAXRED)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_map(cfg_map),
    .cfg_atk_code(cfg_atk_code), .cfg_rel_code(cfg_rel_code),
    .cfg_atk_step(cfg_atk_step), .cfg_rel_step(cfg_rel_step), .vol_db(vol_db),
    .in_valid(in_valid), .in_ready(in_ready), .in_level(in_level),
    .out_valid(out_valid), .out_ready(out_ready), .out_atten(out_atten),
    .out_lim_atten(out_lim_atten)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";

  // stimulus variables
  int b_mode, b_vol, b_iv, b_or;
  int b_map[NCH];
  int b_lvl[NCH];
  int b_ac[2], b_rc[2], b_as[2], b_rs[2];

  // reference model state
  int m_red[2];
  int m_att[NCH];
  bit m_valid;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int drc_atk(int code);
    case (code)
      0: return -31;  1: return -29;  2: return -27;  3: return -25;
      4: return -23;  5: return -21;  6: return -19;  7: return -17;
      8: return -16;  9: return -15; 10: return -14; 11: return -13;
      12: return -12; 13: return -10; 14: return -7; default: return -4;
    endcase
  endfunction

  function automatic int ac_rel(int code);
    case (code)
      1: return -29; 2: return -20; 3: return -16; 4: return -14;
      default: return code - 17;
    endcase
  endfunction

  task automatic model_step();
    bit fire;
    fire = (b_iv != 0) && (!m_valid || (b_or != 0));
    if (fire) begin
      int nred[2];
      for (int l = 0; l < 2; l++) begin
        bit any;
        int pk, at, rt;
        bit always_rel, over, under;
        any = 0; pk = -100000;
        for (int c = 0; c < NCH; c++)
          if (b_map[c] == l + 1) begin
            any = 1;
            if (b_lvl[c] > pk) pk = b_lvl[c];
          end
        if (b_mode == 0) begin
          at = b_ac[l] - 12;
          rt = ac_rel(b_rc[l]);
          always_rel = (b_rc[l] == 0);
        end else begin
          at = drc_atk(b_ac[l]) + b_vol;
          rt = 2 * b_rc[l] - 38 + b_vol;
          always_rel = 0;
        end
        over = any && (pk > at);
        under = !any || always_rel || (pk < rt);
        nred[l] = m_red[l];
        if (over) begin
          nred[l] = m_red[l] + b_as[l];
          if (nred[l] > MAXRED) nred[l] = MAXRED;
        end else if (under) begin
          nred[l] = m_red[l] - b_rs[l];
          if (nred[l] < 0) nred[l] = 0;
        end
      end
      for (int l = 0; l < 2; l++) m_red[l] = nred[l];
      for (int c = 0; c < NCH; c++)
        m_att[c] = (b_map[c] == 1) ? nred[0] : (b_map[c] == 2) ? nred[1] : 0;
      m_valid = 1;
    end else if (b_or != 0) begin
      m_valid = 0;
    end
  endtask

  task automatic compare_outputs();
    chk("out_valid", int'(out_valid), int'(m_valid));
    for (int c = 0; c < NCH; c++)
      chk($sformatf("out_atten[%0d]", c), int'(out_atten[c*GW +: GW]), m_att[c]);
    for (int l = 0; l < 2; l++)
      chk($sformatf("out_lim_atten[%0d]", l), int'(out_lim_atten[l*GW +: GW]), m_red[l]);
  endtask

  task automatic apply();
    cfg_mode = b_mode[0];
    vol_db = b_vol[LW-1:0];
    in_valid = b_iv[0];
    out_ready = b_or[0];
    for (int c = 0; c < NCH; c++) begin
      cfg_map[2*c +: 2] = b_map[c][1:0];
      in_level[c*LW +: LW] = b_lvl[c][LW-1:0];
    end
    for (int l = 0; l < 2; l++) begin
      cfg_atk_code[4*l +: 4] = b_ac[l][3:0];
      cfg_rel_code[4*l +: 4] = b_rc[l][3:0];
      cfg_atk_step[4*l +: 4] = b_as[l][3:0];
      cfg_rel_step[4*l +: 4] = b_rs[l][3:0];
    end
    #1;
    chk("in_ready", int'(in_ready), int'(!m_valid || (b_or != 0)));
    model_step();
  endtask

  task automatic cycle();
    @(negedge clk);
    compare_outputs();
    apply();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic set_levels(int a, int b, int c);
    b_lvl[0] = a; b_lvl[1] = b; b_lvl[2] = c;
  endtask

  initial begin
    b_mode = 0; b_vol = 0; b_iv = 0; b_or = 0;
    for (int c = 0; c < NCH; c++) begin b_map[c] = 0; b_lvl[c] = -60; m_att[c] = 0; end
    for (int l = 0; l < 2; l++) begin
      b_ac[l] = 0; b_rc[l] = 1; b_as[l] = 1; b_rs[l] = 1; m_red[l] = 0;
    end
    m_valid = 0;

    // R1: reset state
    tag = "R1";
    repeat (3) @(negedge clk);
    compare_outputs();
    rst_n = 1'b1;
    run(3);

    // R5: attack with saturation at the ceiling
    tag = "R5";
    b_iv = 1; b_or = 1; b_map[0] = 1;
    b_ac[0] = 0; b_as[0] = 15; b_rc[0] = 1; b_rs[0] = 15;
    set_levels(0, -60, -60);
    run(10);

    // R6: release to the floor, then hold between thresholds
    tag = "R6";
    set_levels(-40, -60, -60);
    run(9);
    b_as[0] = 5; set_levels(-5, -60, -60); run(3);
    set_levels(-12, -60, -60); run(3);
    set_levels(-29, -60, -60); run(3);
    set_levels(-30, -60, -60); b_rs[0] = 2; run(3);

    // R8: minus infinity release always gives gain back
    tag = "R8";
    set_levels(5, -60, -60); b_ac[0] = 0; run(4);
    b_ac[0] = 15; b_rc[0] = 0; b_rs[0] = 3; set_levels(2, -60, -60); run(8);
    for (int code = 1; code < 16; code++) begin
      b_rc[0] = code; b_ac[0] = 15;
      set_levels(ac_rel(code), -60, -60); run(1);
      set_levels(ac_rel(code) - 1, -60, -60); run(1);
      set_levels(20, -60, -60); b_ac[0] = 0; run(1);
    end

    // R7: clip-guard attack table boundaries
    tag = "R7";
    b_rc[0] = 1; b_as[0] = 2;
    for (int code = 0; code < 16; code++) begin
      b_ac[0] = code;
      set_levels(code - 12, -60, -60); run(1);
      set_levels(code - 11, -60, -60); run(1);
    end

    // R3: routing codes, including the unused code
    tag = "R3";
    b_map[0] = 1; b_map[1] = 3; b_map[2] = 2;
    b_ac[1] = 0; b_as[1] = 4; b_rc[1] = 1; b_rs[1] = 1;
    set_levels(-60, 10, 0); run(4);
    b_map[1] = 0; run(2);

    // R4: peak over routed channels; an unrouted limiter decays
    tag = "R4";
    b_map[0] = 1; b_map[1] = 1; b_map[2] = 1; b_ac[0] = 4; b_as[0] = 3;
    set_levels(-30, -5, -50); run(3);
    set_levels(-30, -9, -50); run(2);
    b_rs[1] = 2; run(4);

    // R9: compressor attack table relative to volume
    tag = "R9";
    b_mode = 1; b_vol = -10; b_map[0] = 2; b_map[1] = 0; b_map[2] = 0;
    b_rc[1] = 0; b_as[1] = 1;
    for (int code = 0; code < 16; code++) begin
      b_ac[1] = code;
      set_levels(drc_atk(code) - 10, -60, -60); run(1);
      set_levels(drc_atk(code) - 9, -60, -60); run(1);
    end

    // R10: compressor release table relative to volume
    tag = "R10";
    b_vol = 6; b_ac[1] = 15; b_rs[1] = 1;
    for (int code = 0; code < 16; code++) begin
      b_rc[1] = code;
      set_levels(20, -60, -60); b_ac[1] = 0; run(1);
      b_ac[1] = 15;
      set_levels(2 * code - 38 + 6, -60, -60); run(1);
      set_levels(2 * code - 39 + 6, -60, -60); run(1);
    end

    // R2: random valid and ready with back-pressure
    tag = "R2";
    b_mode = 0; b_vol = 0;
    for (int i = 0; i < 400; i++) begin
      b_iv = $urandom_range(0, 1);
      b_or = ($urandom_range(0, 3) != 0) ? 1 : 0;
      for (int c = 0; c < NCH; c++) begin
        b_map[c] = $urandom_range(0, 3);
        b_lvl[c] = int'($urandom_range(0, 50)) - 45;
      end
      run(1);
    end

    // R11: random configurations, state moves only on accepted frames
    tag = "R11";
    for (int blk = 0; blk < 40; blk++) begin
      b_mode = $urandom_range(0, 1);
      b_vol = int'($urandom_range(0, 30)) - 20;
      for (int l = 0; l < 2; l++) begin
        b_ac[l] = $urandom_range(0, 15); b_rc[l] = $urandom_range(0, 15);
        b_as[l] = $urandom_range(0, 15); b_rs[l] = $urandom_range(0, 15);
      end
      for (int c = 0; c < NCH; c++) b_map[c] = $urandom_range(0, 3);
      for (int i = 0; i < 40; i++) begin
        b_iv = ($urandom_range(0, 3) != 0) ? 1 : 0;
        b_or = $urandom_range(0, 1);
        for (int c = 0; c < NCH; c++) b_lvl[c] = int'($urandom_range(0, 60)) - 50;
        run(1);
      end
    end

    b_iv = 0; b_or = 1;
    run(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL %s watchdog: got %0d expected %0d", tag, 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule